// File: doc/BRIEF.md
# Configuration Access Translator

This block sits in a host bridge between a simple 32-bit CPU register bus and an internal configuration-access bus. Software first loads an index register through one 4 KB window, then reads or writes configuration data through a second 4 KB window. Every data-window access is turned into a single configuration-bus request. Its address is built from the latched index value and the low address bits of the access. Its byte enables and lane-shifted write data come from the access size and offset, and data is little-endian.

Three index formats are recognised. In pass-through form the index already holds the target address. In type-1 form the index holds bus, device, function and register fields. In type-0 form the device is chosen by a one-hot select field in the upper index bits, which the block encodes into a binary slot number. The block also routes four interrupt pins from each of several devices onto four shared lines, which occupy a fixed window of interrupt-controller inputs. It also flags CPU memory addresses that fall inside the hole forwarded to PCI memory space.

Top module: `cfg_xlate`

## Requirements
- R1: The index register is zero after reset. An index-window read returns it in full, whatever the access size. An index-window write changes it only when the size is a word (size code 2); byte (code 0) and halfword (code 1) writes leave it unchanged.
- R2: When index bit 31 is set, the configuration address is the index with bits 1:0 replaced by CPU address bits 1:0.
- R3: When index bit 31 is clear and bit 0 is set, the configuration address is the index with bits 2:0 replaced by CPU address bits 2:0.
- R4: When index bits 31 and 0 are both clear, the configuration address has bits 31:16 zero. Bits 15:11 hold the position of the lowest set bit among index bits 31:11, bits 10:3 are copied from the index, and bits 2:0 are CPU address bits 2:0.
- R5: In the type-0 case with none of index bits 31:11 set, no configuration request is issued. A read returns 0xFFFF_FFFF and a write is dropped.
- R6: Byte enables are 4'b0001 shifted left by address bits 1:0 for a byte, 4'b0011 shifted left by 2*address bit 1 for a halfword, and 4'b1111 for a word. Write data is right-aligned on the CPU side and moved to the enabled lanes, with bits above the access size cleared. Read data is moved down from those lanes and masked to the size.
- R7: A forwarded access raises cfg_req one cycle after it is accepted. cfg_req and its fields hold until cfg_ack is seen. cpu_ready pulses for one cycle in the cycle after the acknowledging edge, and there is exactly one request per access.
- R8: CPU address bit 12 selects the window (0 = index, 1 = data). Bits 11:0 are an offset inside the 4 KB window, and only bits 2:0 of it affect the translation.
- R9: Pin P (0..3) of source k, which has device number SLOT_BASE+k, drives shared line (SLOT_BASE+k+P) mod 4. A line is high while any source routed to it is high.
- R10: Shared lines 0..3 appear on irq_ctl bits 0x1B..0x1E, and every other irq_ctl bit is zero.
- R11: mem_hit is high exactly for memory addresses from 0x8000_0000 up to, but not including, 0xF000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 13 | Bit 12 window select, bits 11:0 offset |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Right-aligned write data |
| cpu_rdata | output | 32 | Right-aligned read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cfg_req | output | 1 | Configuration request |
| cfg_we | output | 1 | Configuration write |
| cfg_addr | output | 32 | Translated configuration address |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Lane-aligned read data, valid with cfg_ack |
| cfg_ack | input | 1 | Request acknowledge |
| src_irq | input | 16 | Pin P of source k at bit 4k+P |
| irq_ctl | output | 32 | Interrupt-controller input levels |
| mem_addr | input | 32 | CPU memory address to classify |
| mem_hit | output | 1 | Address lies in the forwarded hole |

## Verification
An index-window access completes with cpu_ready one cycle after the accepting edge, and an unforwarded type-0 access behaves the same way. A forwarded access shows cfg_req one cycle after acceptance and cpu_ready one cycle after the edge at which cfg_ack is high. The bench therefore drives at falling edges and waits for cpu_ready at falling edges, and its configuration responder samples cfg_req at falling edges with a programmable number of stall cycles. It records address, enables and data at the moment it acknowledges. Interrupt routing and hole decoding are combinational, so they are checked half a cycle after their inputs change.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

    localparam int DW     = 32;
    localparam int SLOT_W = 5;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef struct packed {
        logic          fwd;
        logic [DW-1:0] addr;
    } xlate_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } acc_state_e;

    // Byte lane at which the access starts, aligned to its size
    function automatic logic [1:0] lane_off(input logic [1:0] sz, input logic [1:0] a);
        case (sz)
            SZ_BYTE: lane_off = a;
            SZ_HALF: lane_off = {a[1], 1'b0};
            default: lane_off = 2'b00;
        endcase
    endfunction

    function automatic logic [3:0] lane_be(input logic [1:0] sz, input logic [1:0] a);
        case (sz)
            SZ_BYTE: lane_be = 4'b0001 << a;
            SZ_HALF: lane_be = 4'b0011 << {a[1], 1'b0};
            default: lane_be = 4'b1111;
        endcase
    endfunction

    function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_HALF: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_xlate_addr.sv
module cfg_xlate_addr
    import cfg_xlate_pkg::*;
#(
    parameter int IDSEL_LO = 11
) (
    input  logic [DW-1:0] idx,
    input  logic [2:0]    off,
    output xlate_t        xl
);
    localparam int NSEL = DW - IDSEL_LO;

    logic [NSEL-1:0]   sel;
    logic [NSEL-1:0]   low1;
    logic [SLOT_W-1:0] terms [NSEL];
    logic [SLOT_W-1:0] slot;

    assign sel  = idx[DW-1:IDSEL_LO];
    // isolate the lowest set select bit
    assign low1 = sel & (~sel + NSEL'(1));

    generate
        for (genvar b = 0; b < NSEL; b++) begin : g_enc
            assign terms[b] = low1[b] ? SLOT_W'(b + IDSEL_LO) : '0;
        end
    endgenerate

    always_comb begin
        slot = '0;
        for (int b = 0; b < NSEL; b++) begin
            slot = slot | terms[b];
        end
    end

    always_comb begin
        xl = '0;
        if (idx[DW-1]) begin
            xl.fwd  = 1'b1;
            xl.addr = {idx[DW-1:2], off[1:0]};
        end else if (idx[0]) begin
            xl.fwd  = 1'b1;
            xl.addr = {idx[DW-1:3], off};
        end else begin
            xl.fwd  = |sel;
            xl.addr = {16'h0000, slot, idx[10:3], off};
        end
    end

endmodule

// File: rtl/cfg_xlate_fsm.sv
module cfg_xlate_fsm
    import cfg_xlate_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic          is_data,
    input  logic [1:0]    a_lo,
    input  logic [1:0]    cpu_size,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ready,
    input  xlate_t        xl,
    output logic [DW-1:0] idx_q,
    output logic          cfg_req,
    output logic          cfg_we,
    output logic [DW-1:0] cfg_addr,
    output logic [3:0]    cfg_be,
    output logic [DW-1:0] cfg_wdata,
    input  logic [DW-1:0] cfg_rdata,
    input  logic          cfg_ack
);
    acc_state_e st;
    logic [1:0] rd_off;
    logic [1:0] rd_sz;
    logic [1:0] lo;

    assign lo = lane_off(cpu_size, a_lo);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            idx_q     <= '0;
            cpu_rdata <= '0;
            cpu_ready <= 1'b0;
            cfg_req   <= 1'b0;
            cfg_we    <= 1'b0;
            cfg_addr  <= '0;
            cfg_be    <= '0;
            cfg_wdata <= '0;
            rd_off    <= '0;
            rd_sz     <= '0;
        end else begin
            cpu_ready <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (cpu_req && !cpu_ready) begin
                        if (!is_data) begin
                            if (cpu_we) begin
                                if (cpu_size == SZ_WORD) idx_q <= cpu_wdata;
                            end else begin
                                cpu_rdata <= idx_q;
                            end
                            cpu_ready <= 1'b1;
                        end else if (!xl.fwd) begin
                            if (!cpu_we) cpu_rdata <= '1;
                            cpu_ready <= 1'b1;
                        end else begin
                            cfg_req   <= 1'b1;
                            cfg_we    <= cpu_we;
                            cfg_addr  <= xl.addr;
                            cfg_be    <= lane_be(cpu_size, a_lo);
                            cfg_wdata <= (cpu_wdata & size_mask(cpu_size)) << {lo, 3'b000};
                            rd_off    <= lo;
                            rd_sz     <= cpu_size;
                            st        <= ST_BUSY;
                        end
                    end
                end
                ST_BUSY: begin
                    if (cfg_ack) begin
                        cfg_req   <= 1'b0;
                        cpu_ready <= 1'b1;
                        if (!cfg_we) begin
                            cpu_rdata <= (cfg_rdata >> {rd_off, 3'b000}) & size_mask(rd_sz);
                        end
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfg_xlate_irq.sv
module cfg_xlate_irq #(
    parameter int NSRC      = 4,
    parameter int SLOT_BASE = 12,
    parameter int PIC_W     = 32,
    parameter int PIC_BASE  = 27
) (
    input  logic [NSRC*4-1:0] src_irq,
    output logic [PIC_W-1:0]  irq_ctl
);
    localparam int NLINE = 4;

    logic [NLINE-1:0] lines;

    always_comb begin
        lines = '0;
        for (int k = 0; k < NSRC; k++) begin
            for (int p = 0; p < NLINE; p++) begin
                if (src_irq[k*NLINE+p]) begin
                    lines[2'((SLOT_BASE + k + p) % NLINE)] = 1'b1;
                end
            end
        end
    end

    generate
        for (genvar i = 0; i < PIC_W; i++) begin : g_pic
            if (i >= PIC_BASE && i < PIC_BASE + NLINE) begin : g_on
                assign irq_ctl[i] = lines[i-PIC_BASE];
            end else begin : g_off
                assign irq_ctl[i] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/cfg_xlate_hole.sv
module cfg_xlate_hole #(
    parameter logic [31:0] HOLE_LO = 32'h8000_0000,
    parameter logic [31:0] HOLE_HI = 32'hF000_0000
) (
    input  logic [31:0] mem_addr,
    output logic        mem_hit
);
    assign mem_hit = (mem_addr >= HOLE_LO) && (mem_addr < HOLE_HI);
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
    import cfg_xlate_pkg::*;
#(
    parameter int          WIN_BYTES = 4096,
    parameter int          IDSEL_LO  = 11,
    parameter int          NSRC      = 4,
    parameter int          SLOT_BASE = 12,
    parameter int          PIC_W     = 32,
    parameter int          PIC_BASE  = 27,
    parameter logic [31:0] HOLE_LO   = 32'h8000_0000,
    parameter logic [31:0] HOLE_HI   = 32'hF000_0000,
    localparam int         WIN_BIT   = $clog2(WIN_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [WIN_BIT:0]  cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_ready,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [31:0]       cfg_addr,
    output logic [3:0]        cfg_be,
    output logic [31:0]       cfg_wdata,
    input  logic [31:0]       cfg_rdata,
    input  logic              cfg_ack,
    input  logic [NSRC*4-1:0] src_irq,
    output logic [PIC_W-1:0]  irq_ctl,
    input  logic [31:0]       mem_addr,
    output logic              mem_hit
);
    logic [DW-1:0] idx_q;
    xlate_t        xl;
    logic          unused_offset;

    assign unused_offset = ^cpu_addr[WIN_BIT-1:3];

    cfg_xlate_addr #(.IDSEL_LO(IDSEL_LO)) u_addr (
        .idx (idx_q),
        .off (cpu_addr[2:0]),
        .xl  (xl)
    );

    cfg_xlate_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .is_data   (cpu_addr[WIN_BIT]),
        .a_lo      (cpu_addr[1:0]),
        .cpu_size  (cpu_size),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_ready (cpu_ready),
        .xl        (xl),
        .idx_q     (idx_q),
        .cfg_req   (cfg_req),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_ack   (cfg_ack)
    );

    cfg_xlate_irq #(
        .NSRC(NSRC), .SLOT_BASE(SLOT_BASE), .PIC_W(PIC_W), .PIC_BASE(PIC_BASE)
    ) u_irq (
        .src_irq (src_irq),
        .irq_ctl (irq_ctl)
    );

    cfg_xlate_hole #(.HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)) u_hole (
        .mem_addr (mem_addr),
        .mem_hit  (mem_hit)
    );

endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
    parameter int PIC_W    = 32,
    parameter int PIC_BASE = 27
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_ready,
    input logic             cfg_req,
    input logic             cfg_ack,
    input logic [31:0]      cfg_addr,
    input logic [3:0]       cfg_be,
    input logic [31:0]      idx_q,
    input logic [PIC_W-1:0] irq_ctl,
    input logic [31:0]      mem_addr,
    input logic             mem_hit
);
    localparam logic [PIC_W-1:0] WIN_MASK = PIC_W'(4'hF) << PIC_BASE;

    AST_IDX_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> idx_q == 32'h0); // R1

    AST_TYPE0_UPPER: assert property (@(posedge clk) disable iff (rst)
        cfg_req && !idx_q[31] && !idx_q[0] |-> cfg_addr[31:16] == 16'h0); // R4

    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> ($countones(cfg_be) == 1 || $countones(cfg_be) == 2
                     || $countones(cfg_be) == 4)); // R6

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        cfg_req && !cfg_ack |=> cfg_req); // R7

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        cfg_req && !cfg_ack |=> $stable(cfg_addr) && $stable(cfg_be)); // R7

    AST_ACK_READY: assert property (@(posedge clk) disable iff (rst)
        cfg_req && cfg_ack |=> cpu_ready && !cfg_req); // R7

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready); // R7

    AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> !cpu_ready); // R7

    AST_IRQ_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (irq_ctl & ~WIN_MASK) == '0); // R10

    AST_HOLE_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        mem_hit |-> mem_addr[31] && mem_addr[31:28] != 4'hF); // R11

endmodule

bind cfg_xlate cfg_xlate_chk #(.PIC_W(PIC_W), .PIC_BASE(PIC_BASE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_ready (cpu_ready),
    .cfg_req   (cfg_req),
    .cfg_ack   (cfg_ack),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .idx_q     (idx_q),
    .irq_ctl   (irq_ctl),
    .mem_addr  (mem_addr),
    .mem_hit   (mem_hit)
);

// File: tb/cfg_xlate_tb.sv
module cfg_xlate_tb;

    localparam logic [31:0] RESP = 32'hA1B2C3D4;

    typedef struct packed {
        logic [31:0] idx;
        logic [2:0]  off;
        logic [1:0]  sz;
        logic [31:0] e_addr;
        logic [3:0]  e_be;
        logic [31:0] e_rd;
    } vec_t;

    // R2 pass-through, R3 type-1, R4 type-0, R6 lanes
    localparam vec_t VECS [7] = '{
        '{32'h8000_1234, 3'd3, 2'd0, 32'h8000_1237, 4'h8, 32'h0000_00A1},
        '{32'h8000_0AB8, 3'd6, 2'd1, 32'h8000_0ABA, 4'hC, 32'h0000_A1B2},
        '{32'h0001_0A05, 3'd0, 2'd2, 32'h0001_0A00, 4'hF, 32'hA1B2_C3D4},
        '{32'h00FF_FF07, 3'd5, 2'd0, 32'h00FF_FF05, 4'h2, 32'h0000_00C3},
        '{32'h0000_0B7C, 3'd4, 2'd2, 32'h0000_5B7C, 4'hF, 32'hA1B2_C3D4},
        '{32'h4010_1544, 3'd1, 2'd0, 32'h0000_6541, 4'h2, 32'h0000_00C3},
        '{32'h4000_0002, 3'd7, 2'd1, 32'h0000_F007, 4'hC, 32'h0000_A1B2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [12:0] cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        cfg_req, cfg_we;
    logic [31:0] cfg_addr, cfg_wdata;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_rdata = '0;
    logic        cfg_ack = 1'b0;
    logic [15:0] src_irq = '0;
    logic [31:0] irq_ctl;
    logic [31:0] mem_addr = '0;
    logic        mem_hit;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cfg_xlate u_dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_ack(cfg_ack),
        .src_irq(src_irq), .irq_ctl(irq_ctl),
        .mem_addr(mem_addr), .mem_hit(mem_hit)
    );

    // configuration-bus responder
    int          ack_delay = 0;
    int          wait_cnt = 0;
    int          held = 0;
    int          n_req = 0;
    bit          ready_bad = 0;
    logic [31:0] r_addr = '0;
    logic [31:0] r_wdata = '0;
    logic [3:0]  r_be = '0;
    logic        r_we = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            cfg_ack = 1'b0;
            wait_cnt = 0;
        end else if (cfg_ack) begin
            cfg_ack = 1'b0;
        end else if (cfg_req) begin
            if (cpu_ready) ready_bad = 1;
            if (wait_cnt < ack_delay) begin
                wait_cnt++;
                held++;
            end else begin
                wait_cnt = 0;
                cfg_ack = 1'b1;
                cfg_rdata = RESP;
                n_req++;
                r_addr = cfg_addr;
                r_wdata = cfg_wdata;
                r_be = cfg_be;
                r_we = cfg_we;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [12:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd);
        int n;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ready && n < 1000);
        if (!cpu_ready) begin
            n_chk++; n_fail++;
            $display("FAIL R7 watchdog on access actual=%h expected=%h", 0, 1);
        end
        rd = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int q;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk(cpu_ready == 1'b0, "R7 reset ready", 32'(cpu_ready), 0);
        chk(cfg_req == 1'b0, "R7 reset req", 32'(cfg_req), 0);
        chk(irq_ctl == 32'h0, "R10 reset irq", irq_ctl, 0);
        cpu_op(0, 13'h0000, 2'd2, 0, rd);
        chk(rd == 32'h0, "R1 index reset", rd, 0);

        // R1 / R8: full-word write via high window offset, partial writes ignored
        cpu_op(1, 13'h0FFC, 2'd2, 32'h1234_5678, rd);
        cpu_op(1, 13'h0000, 2'd0, 32'h0000_00FF, rd);
        cpu_op(1, 13'h0002, 2'd1, 32'h0000_ABCD, rd);
        cpu_op(0, 13'h0000, 2'd0, 0, rd);
        chk(rd == 32'h1234_5678, "R1 partial write ignored", rd, 32'h1234_5678);
        chk(n_req == 0, "R8 index window issues no request", n_req, 0);

        // vector table
        for (int i = 0; i < 7; i++) begin
            cpu_op(1, 13'h0000, 2'd2, VECS[i].idx, rd);
            q = n_req;
            cpu_op(0, {1'b1, 9'h000, VECS[i].off}, VECS[i].sz, 0, rd);
            chk(r_addr == VECS[i].e_addr, "R2/R3/R4 cfg_addr", r_addr, VECS[i].e_addr);
            chk(r_be == VECS[i].e_be, "R6 cfg_be", 32'(r_be), 32'(VECS[i].e_be));
            chk(rd == VECS[i].e_rd, "R6 read data", rd, VECS[i].e_rd);
            chk(n_req == q + 1 && r_we == 1'b0, "R7 one read request", n_req - q, 1);
        end

        // R8: data window high offset only uses bits 2:0
        cpu_op(1, 13'h0000, 2'd2, 32'h00FF_FF07, rd);
        cpu_op(0, 13'h1FFD, 2'd0, 0, rd);
        chk(r_addr == 32'h00FF_FF05, "R8 data offset", r_addr, 32'h00FF_FF05);

        // R6 writes with lane shifting
        cpu_op(1, 13'h0000, 2'd2, 32'h0001_0801, rd);
        cpu_op(1, 13'h1002, 2'd1, 32'h0000_BEEF, rd);
        chk(r_we && r_addr == 32'h0001_0802, "R3 write addr", r_addr, 32'h0001_0802);
        chk(r_be == 4'hC, "R6 half be", 32'(r_be), 32'hC);
        chk(r_wdata == 32'hBEEF_0000, "R6 half wdata", r_wdata, 32'hBEEF_0000);
        cpu_op(1, 13'h1001, 2'd0, 32'hFFFF_FF5A, rd);
        chk(r_be == 4'h2, "R6 byte be", 32'(r_be), 32'h2);
        chk(r_wdata == 32'h0000_5A00, "R6 byte wdata masked", r_wdata, 32'h0000_5A00);

        // R5: type-0 with empty select field
        cpu_op(1, 13'h0000, 2'd2, 32'h0000_0744, rd);
        q = n_req;
        cpu_op(0, 13'h1000, 2'd2, 0, rd);
        chk(rd == 32'hFFFF_FFFF, "R5 empty select read", rd, 32'hFFFF_FFFF);
        cpu_op(1, 13'h1004, 2'd2, 32'hDEAD_BEEF, rd);
        chk(n_req == q, "R5 no request issued", n_req - q, 0);

        // R7: stalled acknowledge
        cpu_op(1, 13'h0000, 2'd2, 32'h0001_0A05, rd);
        ack_delay = 5; held = 0; ready_bad = 0; q = n_req;
        cpu_op(0, 13'h1000, 2'd2, 0, rd);
        ack_delay = 0;
        chk(held == 5, "R7 request held during stall", held, 5);
        chk(!ready_bad, "R7 no ready while waiting", 32'(ready_bad), 0);
        chk(rd == RESP && n_req == q + 1, "R7 stalled read data", rd, RESP);

        // R9 / R10 interrupt routing (SLOT_BASE 12, controller base 0x1B)
        src_irq = 16'h0040;            // source 1 pin 2 -> line 3
        @(negedge clk);
        chk(irq_ctl == 32'h4000_0000, "R9 source1 pin2", irq_ctl, 32'h4000_0000);
        src_irq = 16'h0041;            // plus source 0 pin 0 -> line 0
        @(negedge clk);
        chk(irq_ctl == 32'h4800_0000, "R10 two lines", irq_ctl, 32'h4800_0000);
        src_irq = 16'h2040;            // source 3 pin 1 -> line 0, source 0 released
        @(negedge clk);
        chk(irq_ctl == 32'h4800_0000, "R9 shared line", irq_ctl, 32'h4800_0000);
        src_irq = 16'h0000;
        @(negedge clk);
        chk(irq_ctl == 32'h0, "R9 all released", irq_ctl, 0);

        // R11 memory hole bounds
        mem_addr = 32'h7FFF_FFFF; #1;
        chk(mem_hit == 1'b0, "R11 below hole", 32'(mem_hit), 0);
        mem_addr = 32'h8000_0000; #1;
        chk(mem_hit == 1'b1, "R11 hole start", 32'(mem_hit), 1);
        mem_addr = 32'hEFFF_FFFF; #1;
        chk(mem_hit == 1'b1, "R11 hole end", 32'(mem_hit), 1);
        mem_addr = 32'hF000_0000; #1;
        chk(mem_hit == 1'b0, "R11 above hole", 32'(mem_hit), 0);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule